// File: doc/BRIEF.md
# Dual-Edge External Interrupt Request Register

This block watches four external pins that double as a 4-bit input port. It turns every transition on them, rising or falling, into a latched interrupt request, held in one bus-addressable register. Two of the pins are dedicated interrupt inputs, and each owns a request bit. The other two are counter inputs. Each counter input has a select bit that decides whether its transitions count as interrupts, and both counter inputs share a single request bit.

Each pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised sample with the previous one. The request bits stay set until software clears them with a write of zeros to the register. The synchronised pin levels can also be read at a second address as plain port bits. On reset, the edge history takes the present pin levels, so leaving reset never raises a request.

Top module: `edge_irq_req`

## Requirements
- R1: A pin transition shows in the request register after the third rising clock edge that follows it. There are two synchroniser stages and one history stage in the path.
- R2: Any rising or falling transition on `pin_i[0]` sets request bit 0.
- R3: Any rising or falling transition on `pin_i[1]` sets request bit 1.
- R4: A transition on `pin_i[2]` sets request bit 2 only while `cnt_sel_i[0]` is 1. A transition on `pin_i[3]` sets request bit 2 only while `cnt_sel_i[1]` is 1. With the select bit at 0, the transition leaves bit 2 unchanged.
- R5: A read at address 0x00FD returns {5'b0, req[2:0]}. A read at `PORT_ADDR` (default 0x00C6) returns {4'b0, synchronised pins[3:0]}. Any other address reads 0.
- R6: A write to 0x00FD clears each request bit whose data bit is 0 and leaves unchanged each bit whose data bit is 1.
- R7: When an edge and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R8: Reset clears all request bits. Pins held at any level through reset and after it raise no request.
- R9: A set request bit stays set through later transitions until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | External pins: 0 and 1 are interrupt inputs, 2 and 3 are counter inputs |
| cnt_sel_i | input | 2 | Interrupt select for counter pins 2 and 3 |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational) |

## Verification
A detected edge and a software clear can both land on one request bit in the same cycle. The bench provokes this by changing a pin two edges before a clearing write. It times the write so that the write strobe and the detected edge are active at the same rising edge. The bench then reads the register and expects the bit to be set, while a different bit cleared by that same write reads 0.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int NUM_PINS = 4;
    localparam int NUM_REQ  = 3;
    localparam logic [ADDR_W-1:0] REQ_ADDR = 16'h00FD;

    typedef struct packed {
        logic cnt1;
        logic cnt0;
        logic irq1;
        logic irq0;
    } pin_vec_t;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_REQ,
        DEC_PORT
    } dec_t;

    function automatic logic [NUM_REQ-1:0] merge_req(input pin_vec_t e, input logic [1:0] sel);
        return {(e.cnt0 & sel[0]) | (e.cnt1 & sel[1]), e.irq1, e.irq0};
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stage_q[s] <= raw_i;
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= raw_i;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    input  logic [WIDTH-1:0] sync_i,
    output logic [WIDTH-1:0] edge_o
);
    logic [WIDTH-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= raw_i;
        else     hist_q <= sync_i;
    end

    assign edge_o = sync_i ^ hist_q;
endmodule

// File: rtl/req_reg.sv
module req_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] req_o
);
    logic [WIDTH-1:0] req_q, req_d;

    always_comb begin
        req_d = req_q;
        if (wr_en_i) req_d = req_q & keep_i;
        req_d = req_d | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/edge_irq_req.sv
module edge_irq_req
    import edge_irq_pkg::*;
#(
    parameter logic [15:0] PORT_ADDR = 16'h00C6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  pin_i,
    input  logic [1:0]  cnt_sel_i,
    input  logic [15:0] bus_addr_i,
    input  logic        bus_wr_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o
);
    logic [NUM_PINS-1:0] sync_w;
    pin_vec_t            edge_w;
    logic [NUM_REQ-1:0]  set_w;
    logic [NUM_REQ-1:0]  req_q;
    dec_t                dec;

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .raw_i(pin_i), .sync_o(sync_w)
    );

    edge_det #(.WIDTH(NUM_PINS)) u_edge (
        .clk(clk), .rst(rst), .raw_i(pin_i), .sync_i(sync_w), .edge_o(edge_w)
    );

    assign set_w = merge_req(edge_w, cnt_sel_i);

    always_comb begin
        if (bus_addr_i == REQ_ADDR)       dec = DEC_REQ;
        else if (bus_addr_i == PORT_ADDR) dec = DEC_PORT;
        else                              dec = DEC_NONE;
    end

    req_reg #(.WIDTH(NUM_REQ)) u_req (
        .clk(clk), .rst(rst), .set_i(set_w),
        .wr_en_i(bus_wr_i && dec == DEC_REQ),
        .keep_i(bus_wdata_i[NUM_REQ-1:0]),
        .req_o(req_q)
    );

    always_comb begin
        case (dec)
            DEC_REQ:  bus_rdata_o = {{(DATA_W-NUM_REQ){1'b0}}, req_q};
            DEC_PORT: bus_rdata_o = {{(DATA_W-NUM_PINS){1'b0}}, sync_w};
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/edge_irq_req_chk.sv
module edge_irq_req_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  edges,
    input logic [1:0]  cnt_sel_i,
    input logic [2:0]  req_q,
    input logic [15:0] bus_addr_i,
    input logic        bus_wr_i,
    input logic [7:0]  bus_wdata_i
);
    logic wr_hit;
    assign wr_hit = bus_wr_i && bus_addr_i == 16'h00FD;

    // R2
    irq0_set_chk: assert property (@(posedge clk) disable iff (rst) edges[0] |=> req_q[0]);
    // R3
    irq1_set_chk: assert property (@(posedge clk) disable iff (rst) edges[1] |=> req_q[1]);
    // R4
    cnt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!(edges[2] && cnt_sel_i[0]) && !(edges[3] && cnt_sel_i[1]) && !wr_hit)
        |=> req_q[2] == $past(req_q[2]));
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !bus_wdata_i[1] && !edges[1]) |=> !req_q[1]);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !bus_wdata_i[0] && edges[0]) |=> req_q[0]);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q[0] && !wr_hit) |=> req_q[0]);
    // R8
    reset_clr_chk: assert property (@(posedge clk) $past(rst) |-> req_q == 3'b000);
endmodule

bind edge_irq_req edge_irq_req_chk u_chk (
    .clk(clk), .rst(rst), .edges(edge_w), .cnt_sel_i(cnt_sel_i), .req_q(req_q),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i)
);

// File: tb/edge_irq_req_tb.sv
module edge_irq_req_tb;
    localparam logic [15:0] REQ_A  = 16'h00FD;
    localparam logic [15:0] PORT_A = 16'h00C6;
    localparam int NVEC = 9;
    // {pins[3:0], sel[1:0], expected req[2:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'b0001, 2'b00, 3'b001},
        {4'b0000, 2'b00, 3'b001},
        {4'b0010, 2'b00, 3'b010},
        {4'b0110, 2'b00, 3'b000},
        {4'b0010, 2'b01, 3'b100},
        {4'b1010, 2'b01, 3'b000},
        {4'b0010, 2'b10, 3'b100},
        {4'b1110, 2'b11, 3'b100},
        {4'b0001, 2'b11, 3'b111}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pin_i = 4'b1111;
    logic [1:0]  cnt_sel_i = 2'b00;
    logic [15:0] bus_addr_i = 16'h0000;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [7:0]  bus_rdata_o;
    logic [7:0]  rd;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    edge_irq_req u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .cnt_sel_i(cnt_sel_i),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [15:0] a);
        bus_addr_i = a;
        #1;
        rd = bus_rdata_o;
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_addr_i = REQ_A;
        bus_wdata_i = d;
        bus_wr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic settle;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        bus_read(REQ_A);
        check("R8 no request after reset", rd, 8'h00);
        bus_read(PORT_A);
        check("R5 port read", rd, 8'h0F);
        bus_read(16'h0123);
        check("R5 unmapped read", rd, 8'h00);

        pin_i = 4'b0000;
        settle();
        bus_write(8'h00);
        bus_read(REQ_A);
        check("R6 clear all", rd, 8'h00);

        // table of vectors
        for (int i = 0; i < NVEC; i++) begin
            pin_i = VEC[i][8:5];
            cnt_sel_i = VEC[i][4:3];
            settle();
            bus_read(REQ_A);
            check($sformatf("R2/R3/R4 vector %0d", i), rd, {5'b0, VEC[i][2:0]});
            bus_read(PORT_A);
            check($sformatf("R5 port vector %0d", i), rd, {4'b0, VEC[i][8:5]});
            bus_write(8'h00);
            bus_read(REQ_A);
            check($sformatf("R6 clear vector %0d", i), rd, 8'h00);
        end

        // R1 latency: change pin0, visible only after third edge
        cnt_sel_i = 2'b00;
        @(negedge clk);
        pin_i = 4'b0000;
        settle();
        bus_write(8'h00);
        pin_i = 4'b0001;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_read(REQ_A);
        check("R1 not yet after two edges", rd, 8'h00);
        @(posedge clk);
        @(negedge clk);
        bus_read(REQ_A);
        check("R1 set after third edge", rd, 8'h01);

        // R9: later edges keep it set
        pin_i = 4'b0000;
        settle();
        pin_i = 4'b0001;
        settle();
        bus_read(REQ_A);
        check("R9 stays set", rd, 8'h01);

        // R6: write 1 keeps, 0 clears
        pin_i = 4'b0011;
        settle();
        bus_write(8'h02);
        bus_read(REQ_A);
        check("R6 selective clear", rd, 8'h02);

        // R7: edge on bit0 coincides with clearing write of bits 0 and 1
        pin_i = 4'b0010;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_write(8'h00);
        bus_read(REQ_A);
        check("R7 set wins over clear", rd, 8'h01);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule